// File: doc/BRIEF.md
# Frame-Indexed Reverse Translation Search

This block keeps one record for every physical frame of memory. Each record says whether the frame is occupied and, if it is, which process owns it and which virtual page of that process lives there. A lookup supplies a process identifier and a virtual page number. The block then walks the records from frame 0 upwards and reports the position of the first record that matches. That position is the physical frame number. If no record matches, the block reports that the page was not found.

Each clock cycle examines exactly one record, so a lookup can take up to one cycle per frame. A pulse on the start input launches a lookup when the engine is idle. A one-cycle done pulse ends the lookup and comes with a found flag and a frame index. A separate write port loads or invalidates the record of a chosen frame. The write port is refused while a lookup is running, so the table stays fixed for the whole walk.

Top module: `ipt_search_engine`

## Requirements
- R1: After reset `srch_busy`, `srch_done` and `srch_found` are 0, `wr_ready` is 1, and every record is unoccupied, so the first lookup misses.
- R2: While `wr_ready` is 1, a cycle with `wr_en`=1 writes the record at index `wr_frame`. It stores `wr_pid` and `wr_vpn`, and the occupied flag takes the value of `wr_valid` (1 loads the record, 0 clears it). The new contents are visible to any lookup started in a later cycle.
- R3: A cycle with `srch_start`=1 while `srch_busy`=0 captures `srch_pid` and `srch_vpn` as the lookup key, and `srch_busy` reads 1 from the next cycle onward.
- R4: Records are compared one per cycle in ascending index order, starting at 0. A hit at index k raises `srch_done` exactly k+1 clock edges after the edge that accepted the start.
- R5: On a hit, `srch_found` is 1 and `srch_frame` gives the lowest index whose record is occupied and matches the key. A later duplicate is never reported.
- R6: When no record matches, `srch_done` rises NUM_FRAMES edges after the accepting edge, with `srch_found`=0 and `srch_frame`=0.
- R7: An unoccupied record never matches, even when its stored identifier and page equal the key.
- R8: A record matches only when both the process identifier and the virtual page number are equal to the key. Equality in one field alone is no match.
- R9: `srch_start` is ignored while `srch_busy` is 1. The running lookup keeps its key and its timing, and no additional done pulse results.
- R10: While `srch_busy` is 1, `wr_ready` is 0 and `wr_en` has no effect on any record.
- R11: `srch_done` lasts one cycle, and `srch_busy` is 0 in that cycle. `srch_found` and `srch_frame` keep their values until the next done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srch_start | input | 1 | Launch a lookup (accepted only when idle) |
| srch_pid | input | PID_W | Process identifier of the key |
| srch_vpn | input | VPN_W | Virtual page number of the key |
| srch_busy | output | 1 | Lookup in progress |
| srch_done | output | 1 | One-cycle end-of-lookup pulse |
| srch_found | output | 1 | Last lookup hit |
| srch_frame | output | $clog2(NUM_FRAMES) | Frame index of the last hit, 0 on a miss |
| wr_en | input | 1 | Record write request |
| wr_frame | input | $clog2(NUM_FRAMES) | Index of the record to write |
| wr_valid | input | 1 | 1 loads the record, 0 clears it |
| wr_pid | input | PID_W | Owner process identifier to store |
| wr_vpn | input | VPN_W | Virtual page number to store |
| wr_ready | output | 1 | Write port accepts requests (idle) |

## Verification
The bench builds the engine with 16 frames, a 4-bit process identifier and a 6-bit page number. With 16 frames a full miss takes only 16 cycles, so the last record and the miss timing are exercised many times. With the narrow fields, random keys often collide with stored records in one field or in both. This produces partial matches, duplicates and stale unoccupied records without directed setup. Around these random cases, directed sequences poke the start input and the write port in the middle of a lookup to confirm that both are refused.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

  // Scan controller states
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;

  // Index width for a table of n records (at least one bit)
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ipt_table.sv
module ipt_table #(
  parameter int unsigned NUM_FRAMES = 256,
  parameter int unsigned PID_W      = 8,
  parameter int unsigned VPN_W      = 20,
  localparam int unsigned FRAME_W   = ipt_pkg::idx_width(NUM_FRAMES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [FRAME_W-1:0] wfrm,
  input  logic               wvalid,
  input  logic [PID_W-1:0]   wpid,
  input  logic [VPN_W-1:0]   wvpn,
  input  logic [FRAME_W-1:0] rd_idx,
  output logic               rd_valid,
  output logic [PID_W-1:0]   rd_pid,
  output logic [VPN_W-1:0]   rd_vpn
);

  logic [NUM_FRAMES-1:0] valid_q;
  logic [PID_W-1:0]      pid_q [NUM_FRAMES];
  logic [VPN_W-1:0]      vpn_q [NUM_FRAMES];

  // One record per frame, each with its own write enable
  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_rec
    logic sel;
    assign sel = we && (wfrm == FRAME_W'(g));

    // Occupied flag: reset to empty
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   valid_q[g] <= 1'b0;
      else if (sel) valid_q[g] <= wvalid;
    end

    // Payload: no reset, clock enable only
    always_ff @(posedge clk) begin
      if (sel) begin
        pid_q[g] <= wpid;
        vpn_q[g] <= wvpn;
      end
    end
  end

  always_comb begin
    rd_valid = valid_q[rd_idx];
    rd_pid   = pid_q[rd_idx];
    rd_vpn   = vpn_q[rd_idx];
  end

  // R10: no record may change in a cycle without an accepted write
  p_no_write_no_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(valid_q));

endmodule

// File: rtl/ipt_match.sv
module ipt_match #(
  parameter int unsigned PID_W = 8,
  parameter int unsigned VPN_W = 20
) (
  input  logic             en,
  input  logic             rec_valid,
  input  logic [PID_W-1:0] rec_pid,
  input  logic [VPN_W-1:0] rec_vpn,
  input  logic [PID_W-1:0] key_pid,
  input  logic [VPN_W-1:0] key_vpn,
  output logic             hit
);

  logic pid_eq;
  logic vpn_eq;

  always_comb begin
    pid_eq = (rec_pid == key_pid);
    vpn_eq = (rec_vpn == key_vpn);
    hit    = en && rec_valid && pid_eq && vpn_eq;
  end

endmodule

// File: rtl/ipt_scan_ctrl.sv
module ipt_scan_ctrl #(
  parameter int unsigned NUM_FRAMES = 256,
  parameter int unsigned PID_W      = 8,
  parameter int unsigned VPN_W      = 20,
  localparam int unsigned FRAME_W   = ipt_pkg::idx_width(NUM_FRAMES),
  localparam logic [FRAME_W-1:0] LAST_IDX = FRAME_W'(NUM_FRAMES - 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [PID_W-1:0]   in_pid,
  input  logic [VPN_W-1:0]   in_vpn,
  input  logic               hit,
  output logic               busy,
  output logic [FRAME_W-1:0] idx,
  output logic [PID_W-1:0]   key_pid,
  output logic [VPN_W-1:0]   key_vpn,
  output logic               done,
  output logic               found,
  output logic [FRAME_W-1:0] frame
);

  import ipt_pkg::*;

  scan_state_e        state_q, state_d;
  logic [FRAME_W-1:0] idx_q, idx_d;
  logic               done_q, done_d;
  logic               found_q, found_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [PID_W-1:0]   kpid_q;
  logic [VPN_W-1:0]   kvpn_q;
  logic               key_load;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    done_d   = 1'b0;
    found_d  = found_q;
    frame_d  = frame_q;
    key_load = 1'b0;
    unique case (state_q)
      SCAN_IDLE: begin
        if (start) begin
          state_d  = SCAN_RUN;
          idx_d    = '0;
          key_load = 1'b1;
        end
      end
      SCAN_RUN: begin
        if (hit) begin
          state_d = SCAN_IDLE;
          done_d  = 1'b1;
          found_d = 1'b1;
          frame_d = idx_q;
        end else if (idx_q == LAST_IDX) begin
          state_d = SCAN_IDLE;
          done_d  = 1'b1;
          found_d = 1'b0;
          frame_d = '0;
        end else begin
          idx_d = idx_q + FRAME_W'(1);
        end
      end
      default: state_d = SCAN_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
      frame_q <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
      found_q <= found_d;
      frame_q <= frame_d;
    end
  end

  // Key registers: clock enable, no reset
  always_ff @(posedge clk) begin
    if (key_load) begin
      kpid_q <= in_pid;
      kvpn_q <= in_vpn;
    end
  end

  assign busy    = (state_q == SCAN_RUN);
  assign idx     = idx_q;
  assign key_pid = kpid_q;
  assign key_vpn = kvpn_q;
  assign done    = done_q;
  assign found   = found_q;
  assign frame   = frame_q;

  // R4: the walk advances by exactly one record per cycle
  p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (idx_q == $past(idx_q) + FRAME_W'(1)));

  // R4: a walk always begins at record 0
  p_idx_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (idx_q == '0));

  // R9: the key is frozen while a walk runs
  p_key_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(kpid_q) && $stable(kvpn_q)));

  // R11: done follows a walk cycle and lasts a single cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  // R11: result outputs only move on a done pulse
  p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(found_q) && $stable(frame_q)));

endmodule

// File: rtl/ipt_search_engine.sv
module ipt_search_engine #(
  parameter int unsigned NUM_FRAMES = 256,
  parameter int unsigned PID_W      = 8,
  parameter int unsigned VPN_W      = 20,
  localparam int unsigned FRAME_W   = ipt_pkg::idx_width(NUM_FRAMES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               srch_start,
  input  logic [PID_W-1:0]   srch_pid,
  input  logic [VPN_W-1:0]   srch_vpn,
  output logic               srch_busy,
  output logic               srch_done,
  output logic               srch_found,
  output logic [FRAME_W-1:0] srch_frame,
  input  logic               wr_en,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic               wr_valid,
  input  logic [PID_W-1:0]   wr_pid,
  input  logic [VPN_W-1:0]   wr_vpn,
  output logic               wr_ready
);

  logic               busy;
  logic               we;
  logic [FRAME_W-1:0] scan_idx;
  logic [PID_W-1:0]   key_pid;
  logic [VPN_W-1:0]   key_vpn;
  logic               rec_valid;
  logic [PID_W-1:0]   rec_pid;
  logic [VPN_W-1:0]   rec_vpn;
  logic               hit;

  assign wr_ready = !busy;
  assign we       = wr_en && !busy;

  ipt_table #(
    .NUM_FRAMES(NUM_FRAMES), .PID_W(PID_W), .VPN_W(VPN_W)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (we),
    .wfrm    (wr_frame),
    .wvalid  (wr_valid),
    .wpid    (wr_pid),
    .wvpn    (wr_vpn),
    .rd_idx  (scan_idx),
    .rd_valid(rec_valid),
    .rd_pid  (rec_pid),
    .rd_vpn  (rec_vpn)
  );

  ipt_match #(
    .PID_W(PID_W), .VPN_W(VPN_W)
  ) u_match (
    .en       (busy),
    .rec_valid(rec_valid),
    .rec_pid  (rec_pid),
    .rec_vpn  (rec_vpn),
    .key_pid  (key_pid),
    .key_vpn  (key_vpn),
    .hit      (hit)
  );

  ipt_scan_ctrl #(
    .NUM_FRAMES(NUM_FRAMES), .PID_W(PID_W), .VPN_W(VPN_W)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (srch_start),
    .in_pid (srch_pid),
    .in_vpn (srch_vpn),
    .hit    (hit),
    .busy   (busy),
    .idx    (scan_idx),
    .key_pid(key_pid),
    .key_vpn(key_vpn),
    .done   (srch_done),
    .found  (srch_found),
    .frame  (srch_frame)
  );

  assign srch_busy = busy;

  // R10: the write port is closed during a walk
  p_wr_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    srch_busy |-> !wr_ready);

  // R5, R7: a reported hit came from an occupied record
  p_hit_occupied_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_done && srch_found) |-> $past(rec_valid));

  // R8: a reported hit had both key fields equal
  p_hit_both_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_done && srch_found) |-> ($past(rec_pid == key_pid) && $past(rec_vpn == key_vpn)));

  // R3: a walk only begins after an accepted start
  p_walk_needs_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srch_busy) |-> $past(srch_start));

endmodule

// File: tb/sim_ipt_search_engine.sv
module sim_ipt_search_engine;

  localparam int NF = 16;
  localparam int PW = 4;
  localparam int VW = 6;
  localparam int FW = $clog2(NF);

  logic          clk;
  logic          rst_n;
  logic          srch_start;
  logic [PW-1:0] srch_pid;
  logic [VW-1:0] srch_vpn;
  logic          srch_busy;
  logic          srch_done;
  logic          srch_found;
  logic [FW-1:0] srch_frame;
  logic          wr_en;
  logic [FW-1:0] wr_frame;
  logic          wr_valid;
  logic [PW-1:0] wr_pid;
  logic [VW-1:0] wr_vpn;
  logic          wr_ready;

  ipt_search_engine #(.NUM_FRAMES(NF), .PID_W(PW), .VPN_W(VW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .srch_start(srch_start), .srch_pid(srch_pid), .srch_vpn(srch_vpn),
    .srch_busy(srch_busy), .srch_done(srch_done), .srch_found(srch_found),
    .srch_frame(srch_frame),
    .wr_en(wr_en), .wr_frame(wr_frame), .wr_valid(wr_valid),
    .wr_pid(wr_pid), .wr_vpn(wr_vpn), .wr_ready(wr_ready)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  // Reference table
  bit          m_valid [NF];
  int unsigned m_pid   [NF];
  int unsigned m_vpn   [NF];

  function automatic int model_find(input int unsigned p, input int unsigned v);
    for (int i = 0; i < NF; i++)
      if (m_valid[i] && m_pid[i] == p && m_vpn[i] == v) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_write(input int f, input bit val, input int unsigned p,
                          input int unsigned v);
    @(negedge clk);
    check(wr_ready == 1'b1, "R2", "wr_ready when idle", int'(wr_ready), 1);
    wr_en = 1'b1; wr_frame = FW'(f); wr_valid = val;
    wr_pid = PW'(p); wr_vpn = VW'(v);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    m_valid[f] = val; m_pid[f] = p; m_vpn[f] = v;
  endtask

  task automatic clear_all();
    for (int f = 0; f < NF; f++) do_write(f, 1'b0, 0, 0);
  endtask

  // disturb: poke start with another key and a write during the walk
  task automatic run_search(input int unsigned p, input int unsigned v,
                            input bit disturb, input string req);
    int exp_idx;
    int exp_lat;
    int lat;
    bit ok_found;
    bit ok_frame;
    bit held_found;
    int held_frame;
    exp_idx = model_find(p, v);
    exp_lat = (exp_idx >= 0) ? exp_idx + 1 : NF;
    @(negedge clk);
    srch_start = 1'b1; srch_pid = PW'(p); srch_vpn = VW'(v);
    @(posedge clk);
    @(negedge clk);
    srch_start = 1'b0;
    check(srch_busy == 1'b1, "R3", "busy after start", int'(srch_busy), 1);
    lat = 0;
    do begin
      if (disturb && lat == 0) begin
        check(wr_ready == 1'b0, "R10", "wr_ready during walk", int'(wr_ready), 0);
        srch_start = 1'b1; srch_pid = PW'(~p); srch_vpn = VW'(~v);
        wr_en = 1'b1; wr_frame = '0; wr_valid = 1'b1;
        wr_pid = PW'(~p); wr_vpn = VW'(~v);
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
      srch_start = 1'b0; wr_en = 1'b0;
    end while (!srch_done && lat < NF + 4);
    check(lat == exp_lat, exp_idx >= 0 ? "R4" : "R6", "done latency", lat, exp_lat);
    check(srch_busy == 1'b0, "R11", "busy low with done", int'(srch_busy), 0);
    ok_found = (srch_found == (exp_idx >= 0));
    check(ok_found, req, "found flag", int'(srch_found), exp_idx >= 0 ? 1 : 0);
    ok_frame = (int'(srch_frame) == ((exp_idx >= 0) ? exp_idx : 0));
    check(ok_frame, exp_idx >= 0 ? "R5" : "R6", "frame index", int'(srch_frame),
          (exp_idx >= 0) ? exp_idx : 0);
    held_found = srch_found;
    held_frame = int'(srch_frame);
    @(negedge clk);
    check(srch_done == 1'b0, "R11", "done single cycle", int'(srch_done), 0);
    check(srch_found == held_found && int'(srch_frame) == held_frame, "R11",
          "result held", int'(srch_frame), held_frame);
    if (disturb)
      check(srch_busy == 1'b0, "R9", "no walk from ignored start", int'(srch_busy), 0);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int unsigned p;
    int unsigned v;
    int f;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; srch_start = 1'b0; srch_pid = '0; srch_vpn = '0;
    wr_en = 1'b0; wr_frame = '0; wr_valid = 1'b0; wr_pid = '0; wr_vpn = '0;
    for (int i = 0; i < NF; i++) begin m_valid[i] = 0; m_pid[i] = 0; m_vpn[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state and empty table
    check(srch_busy == 1'b0, "R1", "busy after reset", int'(srch_busy), 0);
    check(srch_done == 1'b0, "R1", "done after reset", int'(srch_done), 0);
    check(srch_found == 1'b0, "R1", "found after reset", int'(srch_found), 0);
    check(wr_ready == 1'b1, "R1", "wr_ready after reset", int'(wr_ready), 1);
    run_search(0, 0, 1'b0, "R1");

    // R2: load then find, then clear then miss
    do_write(4, 1'b1, 3, 17);
    run_search(3, 17, 1'b0, "R2");
    do_write(4, 1'b0, 3, 17);
    run_search(3, 17, 1'b0, "R2");

    // R4: hit in the final record
    do_write(NF - 1, 1'b1, 9, 40);
    run_search(9, 40, 1'b0, "R4");

    // R5: duplicates, lowest index reported
    do_write(7, 1'b1, 5, 5);
    do_write(3, 1'b1, 5, 5);
    run_search(5, 5, 1'b0, "R5");

    // R7: unoccupied record with equal contents skipped
    clear_all();
    do_write(2, 1'b1, 6, 33);
    do_write(2, 1'b0, 6, 33);
    do_write(5, 1'b1, 6, 33);
    run_search(6, 33, 1'b0, "R7");

    // R8: single-field matches ignored
    do_write(1, 1'b1, 8, 12);
    do_write(6, 1'b1, 2, 21);
    do_write(9, 1'b1, 8, 21);
    run_search(8, 21, 1'b0, "R8");

    // R6: full miss
    run_search(8, 13, 1'b0, "R6");

    // R9, R10: start and write poked mid-walk, including a hit at 0
    run_search(8, 21, 1'b1, "R9");
    run_search(1, 1, 1'b1, "R9");
    run_search(PW'(~1), VW'(~1), 1'b0, "R10");
    do_write(0, 1'b1, 11, 50);
    run_search(11, 50, 1'b1, "R9");
    run_search(PW'(~11), VW'(~50), 1'b0, "R10");

    // Random traffic
    for (int it = 0; it < 80; it++) begin
      f = int'($urandom_range(NF - 1));
      do_write(f, ($urandom_range(3) != 0), $urandom_range(2**PW - 1),
               $urandom_range(2**VW - 1));
      if ($urandom_range(1) == 1) begin
        f = int'($urandom_range(NF - 1));
        p = m_pid[f]; v = m_vpn[f];
      end else begin
        p = $urandom_range(2**PW - 1); v = $urandom_range(2**VW - 1);
      end
      run_search(p, v, ($urandom_range(3) == 0), "R5");
    end

    finish_run();
  end

endmodule